// File: doc/BRIEF.md
# Windowed Frame Memory Address Counter

This block produces the write address for a display frame memory that is 240 pixels wide (horizontal address 0 to EFh) and 320 lines tall (vertical address 0 to 13Fh). The host programs a rectangular window as horizontal and vertical start and end values. It then places the address at a starting pixel and streams pixel data. Each write strobe moves the address one position along the chosen axis, in the chosen direction.

When the stepped axis reaches the window edge it is facing, it jumps to the opposite edge and the other axis moves one position in its own direction. The host therefore never re-addresses while it fills a rectangle. The memory array and any pixel format conversion sit outside this block.

Top module: `win_addr_ctr`

## Requirements
- R1: After a synchronous active-low reset the address is (h=0, v=0) and the window covers the whole array (h 0..EFh, v 0..13Fh).
- R2: A cycle with addr_load high sets the address to addr_h_in/addr_v_in on the next clock edge, and it wins over a wr_strobe in the same cycle. Inputs above EFh (horizontal) or 13Fh (vertical) are clamped to those limits.
- R3: In a cycle with neither addr_load nor wr_strobe, the address does not change. A window load alone also leaves the address unchanged.
- R4: With vert_step=0 and step_dir[0]=1, a write moves h up by one when h is below the window end, and v is unchanged.
- R5: With vert_step=0 and step_dir[0]=0, a write moves h down by one when h is above the window start, and v is unchanged.
- R6: With vert_step=0, a write at the h edge faced by the direction puts h on the opposite h edge and steps v once. step_dir[1]=1 moves v up and step_dir[1]=0 moves v down, with the same wrapping at the v edges.
- R7: With vert_step=1, v is the stepped axis under step_dir[1]. At the v edge it wraps to the opposite v edge and h steps once under step_dir[0].
- R8: When both axes wrap on one write, the address lands on the window corner that the direction bits start from: the low edge for an increasing axis and the high edge for a decreasing one.
- R9: If a window start is above its end, that axis is a one-position window at the start value. The stepped axis then stays there and every write steps the other axis.
- R10: Window start and end values above the array limit are clamped to the limit when the window is loaded.
- R11: With the address outside the window, an increasing axis wraps to the window start once it is at or beyond the window end, and otherwise moves up by one. A decreasing axis wraps to the window end once it is at or below the window start, and otherwise moves down by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_load | input | 1 | Capture the four window bounds |
| win_h_start | input | 8 | Horizontal window start |
| win_h_end | input | 8 | Horizontal window end |
| win_v_start | input | 9 | Vertical window start |
| win_v_end | input | 9 | Vertical window end |
| addr_load | input | 1 | Load the address directly |
| addr_h_in | input | 8 | Horizontal address to load |
| addr_v_in | input | 9 | Vertical address to load |
| step_dir | input | 2 | Bit 0 is the h direction and bit 1 is the v direction; 1 means increment |
| vert_step | input | 1 | 0 steps h on each write, 1 steps v |
| wr_strobe | input | 1 | One pixel written; advance the address |
| addr_h | output | 8 | Current horizontal address |
| addr_v | output | 9 | Current vertical address |

## Verification
Every result of this block is a registered address. A write, an address load or a window load made before a clock edge shows on addr_h/addr_v just after that edge, and a new window only affects writes made after the edge that captured it. The driver sets its inputs on the falling edge and pushes one expected address for the rising edge that follows. The monitor pops that entry one nanosecond after the rising edge, so each comparison falls in the single cycle in which the result is due.

// File: rtl/win_addr_pkg.sv
// Shared types for the windowed address counter.
// Assumes: bit 0 of the direction field is the horizontal axis and bit 1 the vertical axis.
package win_addr_pkg;
    typedef struct packed {
        logic v_up;   // 1: vertical address increments
        logic h_up;   // 1: horizontal address increments
    } step_dir_t;

    typedef enum logic {
        AXIS_H = 1'b0,
        AXIS_V = 1'b1
    } axis_e;
endpackage

// File: rtl/win_bound.sv
// Holds the window bounds for one axis.
// Values above LAST are clamped to LAST. A start above the end gives a one-position window at the start.
// Assumes: synchronous active-low reset; after reset the bounds cover the full axis.
module win_bound #(
    parameter int W    = 8,
    parameter int LAST = 239
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] start_in,
    input  logic [W-1:0] end_in,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    logic [W-1:0] start_c;
    logic [W-1:0] end_c;

    // Clamp both incoming bounds to the array limit.
    always_comb begin
        start_c = (start_in > LAST_V) ? LAST_V : start_in;
        end_c   = (end_in   > LAST_V) ? LAST_V : end_in;
    end

    // Capture the bounds, collapsing an inverted pair onto its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= LAST_V;
        end else if (load) begin
            lo <= start_c;
            hi <= (start_c > end_c) ? start_c : end_c;
        end
    end

    // R9
    bound_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && (start_in <= LAST_V) && (start_in > end_in) |=> (lo == hi));
    // R10
    bound_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi <= LAST_V) && (lo <= hi));
endmodule

// File: rtl/axis_step.sv
// Works out the next address for one axis.
// Also flags whether the axis sits at the window edge its direction faces, so the other axis can carry.
// Assumes: lo <= hi. Addresses outside the window are handled with >= / <= edge tests.
module axis_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         up,
    output logic         at_edge,
    output logic [W-1:0] nxt
);
    // Edge test and next value, independent of any enable.
    always_comb begin
        if (up) begin
            at_edge = (cur >= hi);
            nxt     = at_edge ? lo : cur + W'(1);
        end else begin
            at_edge = (cur <= lo);
            nxt     = at_edge ? hi : cur - W'(1);
        end
    end
endmodule

// File: rtl/win_addr_ctr.sv
// Windowed address counter for a frame memory of H_LAST+1 by V_LAST+1 pixels.
// Each write strobe steps the chosen axis. At a window edge that axis wraps and the other axis carries.
// Assumes: synchronous active-low reset. An address load takes priority over a write in the same cycle.
module win_addr_ctr
    import win_addr_pkg::*;
#(
    parameter int H_W    = 8,
    parameter int V_W    = 9,
    parameter int H_LAST = 239,
    parameter int V_LAST = 319
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           win_load,
    input  logic [H_W-1:0] win_h_start,
    input  logic [H_W-1:0] win_h_end,
    input  logic [V_W-1:0] win_v_start,
    input  logic [V_W-1:0] win_v_end,
    input  logic           addr_load,
    input  logic [H_W-1:0] addr_h_in,
    input  logic [V_W-1:0] addr_v_in,
    input  logic [1:0]     step_dir,
    input  logic           vert_step,
    input  logic           wr_strobe,
    output logic [H_W-1:0] addr_h,
    output logic [V_W-1:0] addr_v
);
    localparam logic [H_W-1:0] H_LAST_V = H_W'(H_LAST);
    localparam logic [V_W-1:0] V_LAST_V = V_W'(V_LAST);

    step_dir_t      dir;
    axis_e          major;
    logic [H_W-1:0] h_lo, h_hi, h_nxt, h_ld;
    logic [V_W-1:0] v_lo, v_hi, v_nxt, v_ld;
    logic           h_edge, v_edge, h_move, v_move;

    assign dir   = step_dir_t'(step_dir);
    assign major = axis_e'(vert_step);

    win_bound #(.W(H_W), .LAST(H_LAST)) u_hwin (
        .clk(clk), .rst_n(rst_n), .load(win_load),
        .start_in(win_h_start), .end_in(win_h_end), .lo(h_lo), .hi(h_hi)
    );
    win_bound #(.W(V_W), .LAST(V_LAST)) u_vwin (
        .clk(clk), .rst_n(rst_n), .load(win_load),
        .start_in(win_v_start), .end_in(win_v_end), .lo(v_lo), .hi(v_hi)
    );

    axis_step #(.W(H_W)) u_hstep (
        .cur(addr_h), .lo(h_lo), .hi(h_hi), .up(dir.h_up), .at_edge(h_edge), .nxt(h_nxt)
    );
    axis_step #(.W(V_W)) u_vstep (
        .cur(addr_v), .lo(v_lo), .hi(v_hi), .up(dir.v_up), .at_edge(v_edge), .nxt(v_nxt)
    );

    // Decide which axes move: the major axis always moves, the minor one only on a carry.
    always_comb begin
        h_move = (major == AXIS_H) ? 1'b1 : v_edge;
        v_move = (major == AXIS_V) ? 1'b1 : h_edge;
    end

    // Clamp directly loaded addresses to the array.
    always_comb begin
        h_ld = (addr_h_in > H_LAST_V) ? H_LAST_V : addr_h_in;
        v_ld = (addr_v_in > V_LAST_V) ? V_LAST_V : addr_v_in;
    end

    // Address register: a load has priority, otherwise step on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_h <= '0;
            addr_v <= '0;
        end else if (addr_load) begin
            addr_h <= h_ld;
            addr_v <= v_ld;
        end else if (wr_strobe) begin
            if (h_move) addr_h <= h_nxt;
            if (v_move) addr_v <= v_nxt;
        end
    end

    // R2
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load && (addr_h_in <= H_LAST_V) && (addr_v_in <= V_LAST_V)
        |=> (addr_h == $past(addr_h_in)) && (addr_v == $past(addr_v_in)));
    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_h <= H_LAST_V) && (addr_v <= V_LAST_V) || !$past(rst_n));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_load && !wr_strobe |=> $stable(addr_h) && $stable(addr_v));
    // R4
    h_minor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe && !addr_load && !vert_step && !h_edge |=> $stable(addr_v));
    // R6
    h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe && !addr_load && !vert_step && h_edge && step_dir[0]
        |=> addr_h == $past(h_lo));
    // R7
    v_minor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe && !addr_load && vert_step && !v_edge |=> $stable(addr_h));
endmodule

// File: tb/sim_win_addr_ctr.sv
// Scoreboard bench for win_addr_ctr. A driver pushes expected addresses and a monitor pops and compares them.
module sim_win_addr_ctr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_load = 1'b0;
    logic [7:0] win_h_start = '0, win_h_end = '0;
    logic [8:0] win_v_start = '0, win_v_end = '0;
    logic       addr_load = 1'b0;
    logic [7:0] addr_h_in = '0;
    logic [8:0] addr_v_in = '0;
    logic [1:0] step_dir = 2'b11;
    logic       vert_step = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] addr_h;
    logic [8:0] addr_v;

    always #2.5 clk = ~clk;

    win_addr_ctr u0 (
        .clk(clk), .rst_n(rst_n), .win_load(win_load),
        .win_h_start(win_h_start), .win_h_end(win_h_end),
        .win_v_start(win_v_start), .win_v_end(win_v_end),
        .addr_load(addr_load), .addr_h_in(addr_h_in), .addr_v_in(addr_v_in),
        .step_dir(step_dir), .vert_step(vert_step), .wr_strobe(wr_strobe),
        .addr_h(addr_h), .addr_v(addr_v)
    );

    typedef struct {
        int    h;
        int    v;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    // Bench model of the address and window, built from the requirements.
    int mh = 0, mv = 0, whs = 0, whe = 239, wvs = 0, wve = 319;

    function automatic int clampv(int x, int lim);
        return (x > lim) ? lim : x;
    endfunction

    task automatic push(string req);
        exp_t e;
        e.h = mh; e.v = mv; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(string req);
        @(negedge clk);
        win_load = 0; addr_load = 0; wr_strobe = 0;
        push(req);
    endtask

    task automatic load_addr(int h, int v, bit also_wr, string req);
        @(negedge clk);
        win_load = 0; addr_load = 1; wr_strobe = also_wr;
        addr_h_in = 8'(h); addr_v_in = 9'(v);
        mh = clampv(h, 239); mv = clampv(v, 319);
        push(req);
    endtask

    task automatic set_win(int hs, int he, int vs, int ve, string req);
        @(negedge clk);
        addr_load = 0; wr_strobe = 0; win_load = 1;
        win_h_start = 8'(hs); win_h_end = 8'(he);
        win_v_start = 9'(vs); win_v_end = 9'(ve);
        whs = clampv(hs, 239); whe = clampv(he, 239);
        wvs = clampv(vs, 319); wve = clampv(ve, 319);
        if (whs > whe) whe = whs;
        if (wvs > wve) wve = wvs;
        push(req);
    endtask

    task automatic wr(bit [1:0] dir, bit vs, string req);
        bit hu, vu, he_, ve_;
        int nh, nv;
        @(negedge clk);
        win_load = 0; addr_load = 0; wr_strobe = 1;
        step_dir = dir; vert_step = vs;
        hu = dir[0]; vu = dir[1];
        he_ = hu ? (mh >= whe) : (mh <= whs);
        ve_ = vu ? (mv >= wve) : (mv <= wvs);
        nh = hu ? (he_ ? whs : mh + 1) : (he_ ? whe : mh - 1);
        nv = vu ? (ve_ ? wvs : mv + 1) : (ve_ ? wve : mv - 1);
        if (!vs || ve_) mh = nh;
        if (vs || he_) mv = nv;
        push(req);
    endtask

    // Monitor: compare one expected item per cycle, just after the edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (int'(addr_h) != e.h || int'(addr_v) != e.v) begin
                n_bad++;
                $display("FAIL %s: got h=%0h v=%0h expected h=%0h v=%0h",
                         e.req, addr_h, addr_v, e.h, e.v);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        idle("R1");                     // reset address (0,0)
        wr(2'b11, 0, "R4");             // (1,0)
        wr(2'b11, 0, "R4");             // (2,0)
        wr(2'b10, 0, "R5");             // h down to 1
        load_addr(239, 0, 0, "R2");
        wr(2'b11, 0, "R1");             // full window after reset: wrap to (0,1)
        wr(2'b00, 0, "R6");             // h at 0 going down: h->EF, v 1->0
        load_addr(0, 0, 0, "R2");
        wr(2'b00, 0, "R8");             // both wrap: (EF,13F)
        idle("R3");
        set_win(16, 18, 32, 33, "R3");  // window load leaves address
        load_addr(16, 32, 0, "R2");
        for (int i = 0; i < 6; i++) wr(2'b11, 0, (i == 5) ? "R8" : "R6");
        for (int i = 0; i < 4; i++) wr(2'b10, 1, "R7"); // v up, h down
        wr(2'b01, 1, "R7");             // v down
        set_win(48, 5, 10, 12, "R9");   // h collapses to 48
        load_addr(48, 10, 0, "R2");
        for (int i = 0; i < 4; i++) wr(2'b11, 0, "R9");
        set_win(230, 255, 300, 511, "R10");
        load_addr(239, 319, 0, "R2");
        wr(2'b11, 0, "R10");            // wraps to (230,300)
        wr(2'b00, 1, "R10");            // v down at low edge: (229? no, h carries down)
        load_addr(255, 511, 0, "R2");   // clamped
        load_addr(3, 4, 1, "R2");       // load wins over write
        set_win(100, 110, 100, 110, "R3");
        wr(2'b11, 0, "R11");            // h below window: moves up
        load_addr(200, 200, 0, "R2");
        wr(2'b11, 0, "R11");            // h beyond end: wraps to start, v beyond: wraps
        load_addr(50, 50, 0, "R2");
        wr(2'b00, 0, "R11");            // h below start going down: wraps to end
        idle("R3");
        idle("R3");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule